// File: doc/BRIEF.md
# Memory Ordering Unit With Store-Wait Predictor

This block keeps the loads and stores of an out-of-order core in program order while their addresses show up in any order. It finds a load that read memory before an older store to the same place had made its address known. A store's address is checked against every younger load that has already executed. On a match the block asks the pipeline to squash the oldest offending load and everything younger than it. It frees the matching queue entries at once and marks the load's instruction address in a small predictor table.

When a later load is allocated, it looks up that table. If its entry is marked, the load is held back until every store older than it has reported its address. Loads whose entries are not marked may run as soon as they are allocated. The table is wiped on a fixed cycle period, so a load that stopped conflicting goes back to running early. Allocation happens at rename, one memory operation per cycle. The execute stage reports load and store addresses by queue index, and retirement frees queue heads in order. Cache access and data forwarding belong to other blocks.

Top module: `mem_order_unit`

## Requirements
- R1: After reset both queues are empty: the full flags, the squash request and every load-ready bit are 0, and both allocation indices are 0.
- R2: An accepted allocation takes the queue's current tail index, which the block shows on `alloc_ld_idx` or `alloc_st_idx` before the operation arrives. Entries are handed out in program order and wrap at the queue depth. While a queue is full, an allocation to it is ignored and changes neither the tail nor the full flag.
- R3: `ret_ld` and `ret_st` each free the oldest entry of their queue. A retired load's ready bit drops to 0.
- R4: A violation is a store address report whose 8-byte granule (address bits above bit 2) equals that of a younger, already executed load. One cycle after the report, `squash_valid` pulses for one cycle with the load's queue index and instruction address.
- R5: No squash is raised in three cases: the granules differ, the younger load has not executed, or the matching load is older than the store.
- R6: When several younger executed loads match one store, the squash names the oldest of them.
- R7: A violation frees the offending load, every younger load and every store allocated after that load. An allocation offered in the same cycle as the violation is dropped.
- R8: A load execute report and an older store's matching address report in the same cycle also count as a violation.
- R9: Predictor index is instruction address bits [TBL_IW+1:2]. A violation marks the offending load's index. A later load whose index is marked gets ready 0 until every older store has reported its address. A load with an unmarked index is ready as soon as it is allocated and has not executed.
- R10: Every CLEAR_PERIOD cycles all predictor marks are cleared, so a load allocated afterwards at a formerly marked index is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one memory operation this cycle |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_pc | input | PC_W | Instruction address of the allocated operation |
| alloc_ld_idx | output | log2(LQ_DEPTH) | Index the next load will take |
| alloc_st_idx | output | log2(SQ_DEPTH) | Index the next store will take |
| lq_full | output | 1 | Load queue has no free entry |
| sq_full | output | 1 | Store queue has no free entry |
| ld_exec_valid | input | 1 | A load executed |
| ld_exec_idx | input | log2(LQ_DEPTH) | Queue index of that load |
| ld_exec_addr | input | ADDR_W | Address it read |
| st_addr_valid | input | 1 | A store's address is known |
| st_addr_idx | input | log2(SQ_DEPTH) | Queue index of that store |
| st_addr | input | ADDR_W | Store address |
| ret_ld | input | 1 | Retire the oldest load |
| ret_st | input | 1 | Retire the oldest store |
| ld_ready | output | LQ_DEPTH | Per-entry permission for a load to execute |
| squash_valid | output | 1 | Squash request, one-cycle pulse |
| squash_ld_idx | output | log2(LQ_DEPTH) | Queue index of the offending load |
| squash_pc | output | PC_W | Instruction address to refetch from |

## Verification
The bench builds the unit with four-entry load and store queues, a 16-entry predictor and a 256-cycle clear period. The small queues let a handful of allocations reach the full condition and the index wrap. With the short period, a predictor wipe happens within a few hundred idle cycles of a training event. The 8-byte granule and the 32-bit address and instruction widths stay at their defaults, so matching and predictor indexing behave as in the full-size build.

// File: rtl/mo_pkg.sv
package mo_pkg;

  parameter int unsigned MO_ADDR_W  = 32;
  parameter int unsigned MO_PC_W    = 32;
  parameter int unsigned MO_GRAN_LG = 3;

  // distance from base to pos on a ring of 2**bits slots
  function automatic logic [15:0] ring_offset(logic [15:0] base, logic [15:0] pos,
                                              int unsigned bits);
    logic [15:0] mask;
    mask = (16'd1 << bits) - 16'd1;
    return (pos - base) & mask;
  endfunction

  // two addresses fall in one aligned granule of 2**lg bytes
  function automatic logic same_granule(logic [63:0] a, logic [63:0] b, int unsigned lg);
    return (a >> lg) == (b >> lg);
  endfunction

  // number of live entries between head and tail pointers (wrap bit included)
  function automatic logic [15:0] occupancy(logic [15:0] head, logic [15:0] tail,
                                            int unsigned ptr_bits);
    return ring_offset(head, tail, ptr_bits);
  endfunction

endpackage

// File: rtl/mo_wait_table.sv
module mo_wait_table #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned PERIOD = 16384,
  localparam int unsigned ENT   = 1 << IDX_W,
  localparam int unsigned CW    = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_en,
  input  logic [IDX_W-1:0] train_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic             look_hit,
  output logic             clear_pulse,
  output logic [ENT-1:0]   marks
);

  logic [CW-1:0] period_cnt;

  assign clear_pulse = (period_cnt == CW'(PERIOD - 1));
  assign look_hit    = marks[look_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_cnt <= '0;
    end else if (clear_pulse) begin
      period_cnt <= '0;
    end else begin
      period_cnt <= period_cnt + CW'(1);
    end
  end

  // training in the same cycle as a wipe survives the wipe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      marks <= '0;
    end else begin
      if (clear_pulse) marks <= '0;
      if (train_en)    marks[train_idx] <= 1'b1;
    end
  end

endmodule

// File: rtl/mo_load_queue.sv
module mo_load_queue
  import mo_pkg::*;
#(
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PC_W    = 32,
  parameter int unsigned SQ_PTRW = 6,
  localparam int unsigned IW     = $clog2(DEPTH),
  localparam int unsigned PTRW   = IW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic [PC_W-1:0]    alloc_pc,
  input  logic               alloc_wait,
  input  logic [SQ_PTRW-1:0] alloc_sq_snap,
  input  logic               exec_en,
  input  logic [IW-1:0]      exec_idx,
  input  logic [ADDR_W-1:0]  exec_addr,
  input  logic               retire_en,
  input  logic               trunc_en,
  input  logic [PTRW-1:0]    trunc_ptr,
  output logic [PTRW-1:0]    head_ptr,
  output logic [PTRW-1:0]    tail_ptr,
  output logic               full,
  output logic [DEPTH-1:0]   valid_v,
  output logic [DEPTH-1:0]   done_v,
  output logic [DEPTH-1:0]   wait_v,
  output logic [ADDR_W-1:0]  addr_o    [DEPTH],
  output logic [PC_W-1:0]    pc_o      [DEPTH],
  output logic [SQ_PTRW-1:0] sq_snap_o [DEPTH]
);

  logic [15:0] live_cnt;

  assign live_cnt = occupancy(16'(head_ptr), 16'(tail_ptr), PTRW);
  assign full     = (live_cnt == 16'(DEPTH));

  for (genvar g = 0; g < DEPTH; g++) begin : g_valid
    assign valid_v[g] = ring_offset(16'(head_ptr[IW-1:0]), 16'(g), IW) < live_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      done_v   <= '0;
      wait_v   <= '0;
    end else begin
      if (retire_en) head_ptr <= head_ptr + PTRW'(1);
      if (trunc_en) begin
        tail_ptr <= trunc_ptr;
      end else if (alloc_en) begin
        tail_ptr                 <= tail_ptr + PTRW'(1);
        wait_v[tail_ptr[IW-1:0]] <= alloc_wait;
      end
      // a fresh entry starts unexecuted; an execute report on a live entry sets it
      if (alloc_en && !trunc_en) done_v[tail_ptr[IW-1:0]] <= 1'b0;
      if (exec_en)               done_v[exec_idx]         <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en && !trunc_en) begin
      pc_o[tail_ptr[IW-1:0]]      <= alloc_pc;
      sq_snap_o[tail_ptr[IW-1:0]] <= alloc_sq_snap;
    end
    if (exec_en) addr_o[exec_idx] <= exec_addr;
  end

endmodule

// File: rtl/mo_store_queue.sv
module mo_store_queue
  import mo_pkg::*;
#(
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned LQ_PTRW = 6,
  localparam int unsigned IW     = $clog2(DEPTH),
  localparam int unsigned PTRW   = IW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic [LQ_PTRW-1:0] alloc_lq_snap,
  input  logic               addr_en,
  input  logic [IW-1:0]      addr_idx,
  input  logic               retire_en,
  input  logic               trunc_en,
  input  logic [PTRW-1:0]    trunc_ptr,
  output logic [PTRW-1:0]    head_ptr,
  output logic [PTRW-1:0]    tail_ptr,
  output logic               full,
  output logic [DEPTH-1:0]   known_v,
  output logic [LQ_PTRW-1:0] lq_snap_o [DEPTH]
);

  assign full = (occupancy(16'(head_ptr), 16'(tail_ptr), PTRW) == 16'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
      known_v  <= '0;
    end else begin
      if (retire_en) head_ptr <= head_ptr + PTRW'(1);
      if (trunc_en) begin
        tail_ptr <= trunc_ptr;
      end else if (alloc_en) begin
        tail_ptr                  <= tail_ptr + PTRW'(1);
        known_v[tail_ptr[IW-1:0]] <= 1'b0;
      end
      if (addr_en) known_v[addr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en && !trunc_en) lq_snap_o[tail_ptr[IW-1:0]] <= alloc_lq_snap;
  end

endmodule

// File: rtl/mem_order_unit.sv
module mem_order_unit
  import mo_pkg::*;
#(
  parameter int unsigned LQ_DEPTH     = 32,
  parameter int unsigned SQ_DEPTH     = 32,
  parameter int unsigned ADDR_W       = MO_ADDR_W,
  parameter int unsigned PC_W         = MO_PC_W,
  parameter int unsigned GRAN_LG      = MO_GRAN_LG,
  parameter int unsigned TBL_IW       = 6,
  parameter int unsigned CLEAR_PERIOD = 16384,
  localparam int unsigned LQ_IW       = $clog2(LQ_DEPTH),
  localparam int unsigned SQ_IW       = $clog2(SQ_DEPTH),
  localparam int unsigned LQ_PTRW     = LQ_IW + 1,
  localparam int unsigned SQ_PTRW     = SQ_IW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_valid,
  input  logic                alloc_is_store,
  input  logic [PC_W-1:0]     alloc_pc,
  output logic [LQ_IW-1:0]    alloc_ld_idx,
  output logic [SQ_IW-1:0]    alloc_st_idx,
  output logic                lq_full,
  output logic                sq_full,
  input  logic                ld_exec_valid,
  input  logic [LQ_IW-1:0]    ld_exec_idx,
  input  logic [ADDR_W-1:0]   ld_exec_addr,
  input  logic                st_addr_valid,
  input  logic [SQ_IW-1:0]    st_addr_idx,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic                ret_ld,
  input  logic                ret_st,
  output logic [LQ_DEPTH-1:0] ld_ready,
  output logic                squash_valid,
  output logic [LQ_IW-1:0]    squash_ld_idx,
  output logic [PC_W-1:0]     squash_pc
);

  localparam int unsigned TBL_ENT = 1 << TBL_IW;

  // queue state
  logic [LQ_PTRW-1:0] lq_head, lq_tail;
  logic [SQ_PTRW-1:0] sq_head, sq_tail;
  logic [LQ_DEPTH-1:0] lq_valid, lq_done, lq_wait;
  logic [ADDR_W-1:0]   lq_addr    [LQ_DEPTH];
  logic [PC_W-1:0]     lq_pc      [LQ_DEPTH];
  logic [SQ_PTRW-1:0]  lq_sq_snap [LQ_DEPTH];
  logic [SQ_DEPTH-1:0] sq_known;
  logic [LQ_PTRW-1:0]  sq_lq_snap [SQ_DEPTH];

  // named events
  logic               ld_alloc_ok, st_alloc_ok;
  logic               viol_fire;
  logic [LQ_PTRW-1:0] viol_ptr;
  logic [LQ_IW-1:0]   viol_idx;
  logic [LQ_DEPTH-1:0] hit_v;
  logic               tbl_hit, tbl_clear;
  logic [TBL_ENT-1:0] tbl_marks;

  assign ld_alloc_ok  = alloc_valid && !alloc_is_store && !lq_full && !viol_fire;
  assign st_alloc_ok  = alloc_valid &&  alloc_is_store && !sq_full && !viol_fire;
  assign alloc_ld_idx = lq_tail[LQ_IW-1:0];
  assign alloc_st_idx = sq_tail[SQ_IW-1:0];

  mo_load_queue #(
    .DEPTH(LQ_DEPTH), .ADDR_W(ADDR_W), .PC_W(PC_W), .SQ_PTRW(SQ_PTRW)
  ) u_lq (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_en      (ld_alloc_ok),
    .alloc_pc      (alloc_pc),
    .alloc_wait    (tbl_hit),
    .alloc_sq_snap (sq_tail),
    .exec_en       (ld_exec_valid),
    .exec_idx      (ld_exec_idx),
    .exec_addr     (ld_exec_addr),
    .retire_en     (ret_ld),
    .trunc_en      (viol_fire),
    .trunc_ptr     (viol_ptr),
    .head_ptr      (lq_head),
    .tail_ptr      (lq_tail),
    .full          (lq_full),
    .valid_v       (lq_valid),
    .done_v        (lq_done),
    .wait_v        (lq_wait),
    .addr_o        (lq_addr),
    .pc_o          (lq_pc),
    .sq_snap_o     (lq_sq_snap)
  );

  mo_store_queue #(
    .DEPTH(SQ_DEPTH), .LQ_PTRW(LQ_PTRW)
  ) u_sq (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_en      (st_alloc_ok),
    .alloc_lq_snap (lq_tail),
    .addr_en       (st_addr_valid),
    .addr_idx      (st_addr_idx),
    .retire_en     (ret_st),
    .trunc_en      (viol_fire),
    .trunc_ptr     (lq_sq_snap[viol_idx]),
    .head_ptr      (sq_head),
    .tail_ptr      (sq_tail),
    .full          (sq_full),
    .known_v       (sq_known),
    .lq_snap_o     (sq_lq_snap)
  );

  mo_wait_table #(
    .IDX_W(TBL_IW), .PERIOD(CLEAR_PERIOD)
  ) u_tbl (
    .clk         (clk),
    .rst_n       (rst_n),
    .train_en    (viol_fire),
    .train_idx   (lq_pc[viol_idx][TBL_IW+1:2]),
    .look_idx    (alloc_pc[TBL_IW+1:2]),
    .look_hit    (tbl_hit),
    .clear_pulse (tbl_clear),
    .marks       (tbl_marks)
  );

  // ---------------- violation search ----------------
  logic [LQ_PTRW-1:0] st_snap;
  logic [15:0]        young_cnt;

  assign st_snap   = sq_lq_snap[st_addr_idx];
  assign young_cnt = occupancy(16'(st_snap), 16'(lq_tail), LQ_PTRW);

  for (genvar g = 0; g < LQ_DEPTH; g++) begin : g_cmp
    logic              now_exec;
    logic              ran;
    logic [ADDR_W-1:0] ld_a;
    logic              younger;
    assign now_exec = ld_exec_valid && (ld_exec_idx == LQ_IW'(g));
    assign ran      = lq_done[g] || now_exec;
    assign ld_a     = now_exec ? ld_exec_addr : lq_addr[g];
    assign younger  = ring_offset(16'(st_snap[LQ_IW-1:0]), 16'(g), LQ_IW) < young_cnt;
    assign hit_v[g] = st_addr_valid && younger && ran &&
                      same_granule(64'(st_addr), 64'(ld_a), GRAN_LG);
  end

  // oldest match: walk forward from the store's load snapshot
  always_comb begin
    viol_fire = 1'b0;
    viol_ptr  = '0;
    for (int k = 0; k < LQ_DEPTH; k++) begin
      if (!viol_fire && hit_v[LQ_IW'(st_snap[LQ_IW-1:0] + LQ_IW'(k))]) begin
        viol_fire = 1'b1;
        viol_ptr  = st_snap + LQ_PTRW'(k);
      end
    end
  end
  assign viol_idx = viol_ptr[LQ_IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      squash_valid  <= 1'b0;
      squash_ld_idx <= '0;
      squash_pc     <= '0;
    end else begin
      squash_valid <= viol_fire;
      if (viol_fire) begin
        squash_ld_idx <= viol_idx;
        squash_pc     <= lq_pc[viol_idx];
      end
    end
  end

  // ---------------- load issue permission ----------------
  for (genvar g = 0; g < LQ_DEPTH; g++) begin : g_rdy
    logic [15:0] older_cnt;
    logic        resolved;
    assign older_cnt = occupancy(16'(sq_head), 16'(lq_sq_snap[g]), SQ_PTRW);
    always_comb begin
      resolved = 1'b1;
      for (int j = 0; j < SQ_DEPTH; j++) begin
        if (ring_offset(16'(sq_head[SQ_IW-1:0]), 16'(j), SQ_IW) < older_cnt && !sq_known[j])
          resolved = 1'b0;
      end
    end
    assign ld_ready[g] = lq_valid[g] && !lq_done[g] && (!lq_wait[g] || resolved);
  end

endmodule

// File: rtl/mem_order_unit_chk.sv
module mem_order_unit_chk #(
  parameter int unsigned LQ_IW   = 5,
  parameter int unsigned TBL_ENT = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               alloc_valid,
  input logic               alloc_is_store,
  input logic               ret_ld,
  input logic               lq_full,
  input logic [LQ_IW-1:0]   alloc_ld_idx,
  input logic               squash_valid,
  input logic [LQ_IW-1:0]   squash_ld_idx,
  input logic               st_addr_valid,
  input logic               viol_fire,
  input logic [LQ_IW-1:0]   viol_idx,
  input logic               tbl_clear,
  input logic [TBL_ENT-1:0] tbl_marks
);

  AST_VIOL_SQUASHES: assert property (@(posedge clk) disable iff (!rst_n)
    viol_fire |=> squash_valid && squash_ld_idx == $past(viol_idx)); // R4

  AST_SQUASH_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |-> $past(st_addr_valid)); // R4

  AST_FLUSH_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    viol_fire |=> alloc_ld_idx == $past(viol_idx)); // R7

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lq_full && alloc_valid && !alloc_is_store && !ret_ld && !viol_fire
      |=> lq_full && $stable(alloc_ld_idx)); // R2

  AST_TABLE_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_clear && !viol_fire |=> tbl_marks == '0); // R10

endmodule

bind mem_order_unit mem_order_unit_chk #(
  .LQ_IW(LQ_IW), .TBL_ENT(TBL_ENT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .alloc_valid    (alloc_valid),
  .alloc_is_store (alloc_is_store),
  .ret_ld         (ret_ld),
  .lq_full        (lq_full),
  .alloc_ld_idx   (alloc_ld_idx),
  .squash_valid   (squash_valid),
  .squash_ld_idx  (squash_ld_idx),
  .st_addr_valid  (st_addr_valid),
  .viol_fire      (viol_fire),
  .viol_idx       (viol_idx),
  .tbl_clear      (tbl_clear),
  .tbl_marks      (tbl_marks)
);

// File: tb/mem_order_unit_test.sv
`timescale 1ns/1ps
module mem_order_unit_test;

  localparam int LQD = 4;
  localparam int SQD = 4;
  localparam int PER = 256;
  localparam int LIW = 2;
  localparam int SIW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            alloc_valid, alloc_is_store;
  logic [31:0]     alloc_pc;
  logic [LIW-1:0]  alloc_ld_idx;
  logic [SIW-1:0]  alloc_st_idx;
  logic            lq_full, sq_full;
  logic            ld_exec_valid;
  logic [LIW-1:0]  ld_exec_idx;
  logic [31:0]     ld_exec_addr;
  logic            st_addr_valid;
  logic [SIW-1:0]  st_addr_idx;
  logic [31:0]     st_addr;
  logic            ret_ld, ret_st;
  logic [LQD-1:0]  ld_ready;
  logic            squash_valid;
  logic [LIW-1:0]  squash_ld_idx;
  logic [31:0]     squash_pc;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mem_order_unit #(
    .LQ_DEPTH(LQD), .SQ_DEPTH(SQD), .ADDR_W(32), .PC_W(32),
    .GRAN_LG(3), .TBL_IW(4), .CLEAR_PERIOD(PER)
  ) uut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 0; alloc_is_store = 0; alloc_pc = '0;
    ld_exec_valid = 0; ld_exec_idx = '0; ld_exec_addr = '0;
    st_addr_valid = 0; st_addr_idx = '0; st_addr = '0;
    ret_ld = 0; ret_st = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic alloc(bit st, logic [31:0] pc);
    alloc_valid = 1; alloc_is_store = st; alloc_pc = pc;
    @(negedge clk); idle();
  endtask

  task automatic ld_exec(int idx, logic [31:0] a);
    ld_exec_valid = 1; ld_exec_idx = LIW'(idx); ld_exec_addr = a;
    @(negedge clk); idle();
  endtask

  task automatic st_resolve(int idx, logic [31:0] a);
    st_addr_valid = 1; st_addr_idx = SIW'(idx); st_addr = a;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 lq_full", lq_full, 0);
    check("R1 sq_full", sq_full, 0);
    check("R1 squash", squash_valid, 0);
    check("R1 ld_ready", ld_ready, 0);
    check("R1 ld idx", alloc_ld_idx, 0);
    check("R1 st idx", alloc_st_idx, 0);
  endtask

  task automatic t_basic();
    do_reset();
    alloc(1, 32'h1000);
    alloc(0, 32'h2040);
    check("R9 unmarked ready", ld_ready, 4'b0001);
    ld_exec(0, 32'h100);
    st_resolve(0, 32'h104);
    check("R4 squash", squash_valid, 1);
    check("R4 squash idx", squash_ld_idx, 0);
    check("R4 squash pc", squash_pc, 32'h2040);
    check("R7 lq freed", alloc_ld_idx, 0);
    check("R7 older store kept", alloc_st_idx, 1);
    @(negedge clk);
    check("R4 pulse ends", squash_valid, 0);
  endtask

  task automatic t_nomatch();
    do_reset();
    alloc(1, 32'h1000);
    alloc(0, 32'h2000);
    ld_exec(0, 32'h100);
    st_resolve(0, 32'h108);
    check("R5 other granule", squash_valid, 0);
    alloc(1, 32'h1004);
    alloc(0, 32'h2004);
    st_resolve(1, 32'h300);
    check("R5 unexecuted load", squash_valid, 0);
    ld_exec(1, 32'h300);
    check("R5 late load", squash_valid, 0);
    check("R5 nothing freed", alloc_ld_idx, 2);
    do_reset();
    alloc(0, 32'h2000);
    ld_exec(0, 32'h400);
    alloc(1, 32'h1000);
    st_resolve(0, 32'h400);
    check("R5 older load", squash_valid, 0);
  endtask

  task automatic t_oldest();
    do_reset();
    alloc(1, 32'h1000);   // S0
    alloc(0, 32'h2000);   // L0
    alloc(0, 32'h2004);   // L1
    alloc(1, 32'h1004);   // S1
    alloc(0, 32'h2008);   // L2
    check("R2 ld order", alloc_ld_idx, 3);
    ld_exec(0, 32'h508);
    ld_exec(1, 32'h500);
    ld_exec(2, 32'h504);
    st_resolve(0, 32'h500);
    check("R6 oldest match", squash_ld_idx, 1);
    check("R6 squash pc", squash_pc, 32'h2004);
    check("R7 lq truncated", alloc_ld_idx, 1);
    check("R7 younger store freed", alloc_st_idx, 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    alloc(1, 32'h1000);
    alloc(0, 32'h2000);
    ld_exec_valid = 1; ld_exec_idx = 0; ld_exec_addr = 32'h600;
    st_addr_valid = 1; st_addr_idx = 0; st_addr = 32'h607;
    @(negedge clk); idle();
    check("R8 same cycle", squash_valid, 1);
  endtask

  task automatic t_drop_alloc();
    do_reset();
    alloc(1, 32'h1000);
    alloc(0, 32'h2000);
    ld_exec(0, 32'h700);
    st_addr_valid = 1; st_addr_idx = 0; st_addr = 32'h700;
    alloc_valid = 1; alloc_is_store = 1; alloc_pc = 32'h1010;
    @(negedge clk); idle();
    check("R7 alloc dropped", alloc_st_idx, 1);
    check("R7 load freed", alloc_ld_idx, 0);
  endtask

  task automatic train_p();
    alloc(1, 32'h1000);          // S0
    alloc(0, 32'h2040);          // predictor index 0
    ld_exec(0, 32'h800);
    st_resolve(0, 32'h800);
  endtask

  task automatic t_wait();
    do_reset();
    train_p();
    check("R9 training squash", squash_valid, 1);
    alloc(1, 32'h1004);          // S1, address unknown
    alloc(0, 32'h2040);          // marked, idx0
    check("R9 marked waits", ld_ready, 4'b0000);
    alloc(0, 32'h2044);          // index 1, unmarked
    check("R9 unmarked goes", ld_ready, 4'b0010);
    st_resolve(1, 32'h900);
    check("R9 released", ld_ready, 4'b0011);
  endtask

  task automatic t_clear();
    do_reset();
    train_p();
    alloc(1, 32'h1004);
    repeat (2 * PER) @(negedge clk);
    alloc(0, 32'h2040);
    check("R10 wiped", ld_ready, 4'b0001);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < LQD; i++) alloc(0, 32'h3000 + 32'(i * 4));
    check("R2 lq full", lq_full, 1);
    check("R2 wrapped idx", alloc_ld_idx, 0);
    alloc(0, 32'h3100);
    check("R2 ignored full", lq_full, 1);
    check("R2 tail kept", alloc_ld_idx, 0);
    check("R2 all ready", ld_ready, 4'b1111);
    ret_ld = 1; @(negedge clk); idle();
    check("R3 head freed", lq_full, 0);
    check("R3 ready drops", ld_ready, 4'b1110);
    alloc(0, 32'h3200);
    check("R3 reuse", alloc_ld_idx, 1);
    check("R3 full again", lq_full, 1);
    for (int i = 0; i < SQD; i++) alloc(1, 32'h4000 + 32'(i * 4));
    check("R2 sq full", sq_full, 1);
    ret_st = 1; @(negedge clk); idle();
    check("R3 sq head freed", sq_full, 0);
  endtask

  initial begin
    idle();
    rst_n = 0;
    t_reset();
    t_basic();
    t_nomatch();
    t_oldest();
    t_same_cycle();
    t_drop_alloc();
    t_wait();
    t_clear();
    t_full();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule